// File: doc/BRIEF.md
# Address-Decoded NAND Pin Bridge

This block connects a simple memory-mapped bus to a raw 8-bit NAND flash device. Accesses to the flash window do not go through a pin register. The low address bits of each access set the latch and select pins for that one access: command latch, address latch, chip select, spare-area select and write protect. The block latches those bits when the access starts. It then drives an active-low write or read strobe, followed by a hold phase and a recovery phase. All three phases are sized by programmable counts.

Software sends a command by writing a byte to an address whose command-latch and chip-select bits are set. It sends an address byte with the address-latch and chip-select bits set, and it moves data with chip select alone. It then polls the status register until the complete flag is set. A flash read returns zero on the bus. The captured byte is collected afterwards from the data register. A control register holds the mode enable, the chip enable and the pin polarities.

Top module: `nand_pin_bridge`

## Requirements
- R1: During a flash-window access (address bit 7 = 0), nand_ale_o is high for the whole access if address bit 2 was set, and nand_cle_o is high if address bit 3 was set. Both are low when no access is running.
- R2: Address bit 4 selects chip select, bit 5 spare select and bit 6 write protect for the access. Chip select is only active when control bit 0 (mode) and control bit 20 (chip enable) are both set. Each of these pins is driven as active XOR its polarity bit (control bits 4, 5 and 6; 1 = active low).
- R3: A flash write drives nand_we_n_o low for (wr_wait+1)*M cycles, starting the cycle after the request edge. Here M = mult field + 1 clocks per unit. nand_dq_o carries the written byte with nand_dq_oe_o high through the strobe and the following hold*M cycles.
- R4: A flash read drives nand_re_n_o low for (rd_wait+1)*M cycles. The byte present on nand_dq_i in the last low cycle is stored and read back at register offset 3 (address 0x8C).
- R5: Status (address 0x84): bit 0 equals nand_rb_i. Bit 3 (complete) clears at the start edge and sets again (wait+1+hold+recov)*M cycles later.
- R6: The timing register (address 0x88) holds rd_wait[3:0], wr_wait[7:4], hold[11:8], recov[15:12] and mult[17:16]. It resets to 0x31122: read and write wait 2, hold 1, recovery 1, 4 clocks per unit.
- R7: A flash-window request that arrives while an access is running is ignored. It neither restarts the strobe nor changes the pins.
- R8: With mode (control bit 0) clear, flash-window accesses produce no strobe. Chip select stays inactive, complete stays set, and a flash read clears the data register to zero.
- R9: The control register (address 0x80) keeps bits 0, 1, 4-7 and 20. All other bits read as zero.
- R10: After reset the strobes are high, both latch pins are low, the control register reads 0 and complete reads 1.
- R11: A bus read of the flash window returns zero on bus_rdata_o one cycle later. A register read returns its value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Single-cycle bus request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Bit 7 selects registers; in the flash window bits 6..2 select pins |
| bus_wdata_i | input | 32 | Write data; flash writes use bits 7..0 |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| nand_dq_i | input | 8 | Flash data bus in |
| nand_dq_o | output | 8 | Flash data bus out |
| nand_dq_oe_o | output | 1 | Output enable for nand_dq_o |
| nand_rb_i | input | 1 | Flash ready/busy |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_cs_o | output | 1 | Chip select (polarity programmable) |
| nand_spare_o | output | 1 | Spare-area select (polarity programmable) |
| nand_wp_o | output | 1 | Write protect (polarity programmable) |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |

## Verification
Every flash pin is due in the cycle after the request edge and keeps its value for a length set by the timing fields. The bench model therefore counts an age from the start edge and derives strobe, hold and recovery windows from the timing it has mirrored. Pins are compared with the model at every falling edge. Register and status values appear one cycle after the read request, so each bus read samples bus_rdata_o at the next falling edge. The captured flash byte is predicted from the nand_dq_i value in the last strobe cycle, and it is checked only after complete has been polled set.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam int CNT_W    = 4;
  localparam int MULT_W   = 2;
  localparam int REG_W    = 32;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int WIN_BIT  = 7;
  localparam int PIN_LO   = 2;
  localparam int PIN_HI   = 6;
  localparam int ST_RB    = 0;
  localparam int ST_DONE  = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_STROBE, PH_HOLD, PH_RECOV} phase_e;
  typedef enum logic [1:0] {SEL_CTRL, SEL_STAT, SEL_TIM, SEL_DATA} reg_sel_e;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic [CNT_W-1:0]  recov;
    logic [CNT_W-1:0]  hold;
    logic [CNT_W-1:0]  wr_wait;
    logic [CNT_W-1:0]  rd_wait;
  } timing_t;

  typedef struct packed {
    logic ce;
    logic pre_pol;
    logic wp_pol;
    logic se_pol;
    logic cs_pol;
    logic cs_mux;
    logic mode;
  } ctrl_t;

  // access pin bits, in address order bit2..bit6
  typedef struct packed {
    logic wp;
    logic se;
    logic cs;
    logic cle;
    logic ale;
  } acc_t;

  localparam timing_t TIM_RST = '{mult: 2'd3, recov: 4'd1, hold: 4'd1, wr_wait: 4'd2, rd_wait: 4'd2};

  function automatic ctrl_t word_to_ctrl(logic [REG_W-1:0] w);
    ctrl_t c;
    c.ce      = w[20];
    c.pre_pol = w[7];
    c.wp_pol  = w[6];
    c.se_pol  = w[5];
    c.cs_pol  = w[4];
    c.cs_mux  = w[1];
    c.mode    = w[0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_to_word(ctrl_t c);
    logic [REG_W-1:0] w;
    w     = '0;
    w[20] = c.ce;
    w[7]  = c.pre_pol;
    w[6]  = c.wp_pol;
    w[5]  = c.se_pol;
    w[4]  = c.cs_pol;
    w[1]  = c.cs_mux;
    w[0]  = c.mode;
    return w;
  endfunction
endpackage

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_bridge_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    rd_i,
  input  timing_t tim_i,
  output logic    we_n_o,
  output logic    re_n_o,
  output logic    oe_o,
  output logic    capture_o,
  output logic    busy_o,
  output logic    complete_o
);
  phase_e            phase_q, nxt_phase;
  logic [CNT_W-1:0]  units_q, nxt_units;
  logic [MULT_W-1:0] pre_q;
  logic              rd_q, done_q, tick;

  assign tick = (pre_q == '0);

  always_comb begin
    nxt_phase = PH_IDLE;
    nxt_units = '0;
    unique case (phase_q)
      PH_STROBE: begin
        if (tim_i.hold != '0) begin
          nxt_phase = PH_HOLD;
          nxt_units = tim_i.hold - 1'b1;
        end else if (tim_i.recov != '0) begin
          nxt_phase = PH_RECOV;
          nxt_units = tim_i.recov - 1'b1;
        end
      end
      PH_HOLD: begin
        if (tim_i.recov != '0) begin
          nxt_phase = PH_RECOV;
          nxt_units = tim_i.recov - 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      units_q <= '0;
      pre_q   <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b1;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= PH_STROBE;
        units_q <= rd_i ? tim_i.rd_wait : tim_i.wr_wait;
        pre_q   <= tim_i.mult;
        rd_q    <= rd_i;
        done_q  <= 1'b0;
      end
    end else if (!tick) begin
      pre_q <= pre_q - 1'b1;
    end else begin
      pre_q <= tim_i.mult;
      if (units_q != '0) begin
        units_q <= units_q - 1'b1;
      end else begin
        phase_q <= nxt_phase;
        units_q <= nxt_units;
        if (nxt_phase == PH_IDLE) done_q <= 1'b1;
      end
    end
  end

  assign we_n_o     = !(phase_q == PH_STROBE && !rd_q);
  assign re_n_o     = !(phase_q == PH_STROBE && rd_q);
  assign oe_o       = !rd_q && (phase_q == PH_STROBE || phase_q == PH_HOLD);
  assign capture_o  = (phase_q == PH_STROBE) && rd_q && tick && (units_q == '0);
  assign busy_o     = (phase_q != PH_IDLE);
  assign complete_o = done_q;

  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> !complete_o); // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(complete_o) |-> $past(busy_o)); // R5
  AST_CAPTURE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> re_n_o); // R4
endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_bridge_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  busy_i,
  input  acc_t  acc_i,
  input  ctrl_t ctrl_i,
  output logic  cle_o,
  output logic  ale_o,
  output logic  cs_o,
  output logic  spare_o,
  output logic  wp_o
);
  logic cs_act;

  assign cs_act  = busy_i && acc_i.cs && ctrl_i.ce && ctrl_i.mode;
  assign cle_o   = busy_i && acc_i.cle;
  assign ale_o   = busy_i && acc_i.ale;
  assign cs_o    = cs_act ^ ctrl_i.cs_pol;
  assign spare_o = (busy_i && acc_i.se) ^ ctrl_i.se_pol;
  assign wp_o    = (busy_i && acc_i.wp) ^ ctrl_i.wp_pol;

  AST_IDLE_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !cle_o && !ale_o); // R1
  AST_MODE_OFF_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.mode |-> cs_o == ctrl_i.cs_pol); // R8
endmodule

// File: rtl/nand_reg_file.sv
module nand_reg_file
  import nand_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              reg_win_i,
  input  reg_sel_e          sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              rb_i,
  input  logic              complete_i,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] cap_data_i,
  input  logic              zero_data_i,
  output ctrl_t             ctrl_o,
  output timing_t           tim_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int TIM_W = $bits(timing_t);

  ctrl_t             ctrl_q;
  timing_t           tim_q;
  logic [BYTE_W-1:0] data_q;
  logic [REG_W-1:0]  rdata_q, rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (sel_i)
      SEL_CTRL: rd_mux = ctrl_to_word(ctrl_q);
      SEL_STAT: begin
        rd_mux[ST_RB]   = rb_i;
        rd_mux[ST_DONE] = complete_i;
      end
      SEL_TIM:  rd_mux[TIM_W-1:0]  = tim_q;
      SEL_DATA: rd_mux[BYTE_W-1:0] = data_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      tim_q   <= TIM_RST;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (req_i && we_i && reg_win_i) begin
        if (sel_i == SEL_CTRL) ctrl_q <= word_to_ctrl(wdata_i);
        if (sel_i == SEL_TIM)  tim_q  <= timing_t'(wdata_i[TIM_W-1:0]);
      end
      if (cap_i)            data_q <= cap_data_i;
      else if (zero_data_i) data_q <= '0;
      if (req_i && !we_i) rdata_q <= reg_win_i ? rd_mux : '0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign tim_o   = tim_q;
  assign rdata_o = rdata_q;

  AST_FLASH_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && !reg_win_i |=> rdata_o == '0); // R11
endmodule

// File: rtl/nand_pin_bridge.sv
module nand_pin_bridge
  import nand_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic [BYTE_W-1:0] nand_dq_i,
  output logic [BYTE_W-1:0] nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic              nand_rb_i,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_cs_o,
  output logic              nand_spare_o,
  output logic              nand_wp_o,
  output logic              nand_we_n_o,
  output logic              nand_re_n_o
);
  ctrl_t             ctrl;
  timing_t           tim;
  acc_t              acc_q;
  logic [BYTE_W-1:0] wbyte_q;
  logic              reg_win, flash_req, start, bypass_rd;
  logic              busy, complete, capture, oe;

  assign reg_win   = bus_addr_i[WIN_BIT];
  assign flash_req = bus_req_i && !reg_win;
  assign start     = flash_req && ctrl.mode && !busy;
  assign bypass_rd = flash_req && !ctrl.mode && !busy && !bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      wbyte_q <= '0;
    end else if (start) begin
      acc_q   <= acc_t'(bus_addr_i[PIN_HI:PIN_LO]);
      wbyte_q <= bus_wdata_i[BYTE_W-1:0];
    end
  end

  nand_reg_file u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (bus_req_i),
    .we_i        (bus_we_i),
    .reg_win_i   (reg_win),
    .sel_i       (reg_sel_e'(bus_addr_i[3:2])),
    .wdata_i     (bus_wdata_i),
    .rb_i        (nand_rb_i),
    .complete_i  (complete),
    .cap_i       (capture),
    .cap_data_i  (nand_dq_i),
    .zero_data_i (bypass_rd),
    .ctrl_o      (ctrl),
    .tim_o       (tim),
    .rdata_o     (bus_rdata_o)
  );

  nand_strobe_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .rd_i       (!bus_we_i),
    .tim_i      (tim),
    .we_n_o     (nand_we_n_o),
    .re_n_o     (nand_re_n_o),
    .oe_o       (oe),
    .capture_o  (capture),
    .busy_o     (busy),
    .complete_o (complete)
  );

  nand_pin_drive u_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy),
    .acc_i   (acc_q),
    .ctrl_i  (ctrl),
    .cle_o   (nand_cle_o),
    .ale_o   (nand_ale_o),
    .cs_o    (nand_cs_o),
    .spare_o (nand_spare_o),
    .wp_o    (nand_wp_o)
  );

  assign nand_dq_oe_o = oe;
  assign nand_dq_o    = oe ? wbyte_q : '0;

  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && flash_req |=> $stable(acc_q) && $stable(wbyte_q)); // R7
  AST_WE_DRIVES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_n_o |-> nand_dq_oe_o); // R3
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_we_n_o || nand_re_n_o); // R3
endmodule

// File: tb/nand_pin_bridge_bench.sv
module nand_pin_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  dq_in, dq_out;
  logic        dq_oe, rb;
  logic        cle, ale, cs, spare, wp, we_n, re_n;

  int checks = 0;
  int errors = 0;
  int we_low_cnt = 0;

  // model state
  logic [31:0] ctrl_m, tim_m;
  int          age, s_len, sh_len, t_len;
  logic        cur_rd, comp_m;
  logic [4:0]  bits_m;
  logic [7:0]  byte_m, exp_data;

  nand_pin_bridge u_nand_pin_bridge (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .nand_dq_i(dq_in), .nand_dq_o(dq_out), .nand_dq_oe_o(dq_oe),
    .nand_rb_i(rb), .nand_cle_o(cle), .nand_ale_o(ale), .nand_cs_o(cs),
    .nand_spare_o(spare), .nand_wp_o(wp), .nand_we_n_o(we_n), .nand_re_n_o(re_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) dq_in <= dq_in + 8'd37;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_m <= '0; tim_m <= 32'h31122; age <= 0; comp_m <= 1'b1;
      cur_rd <= 1'b0; bits_m <= '0; byte_m <= '0; exp_data <= '0;
      s_len <= 0; sh_len <= 0; t_len <= 0;
    end else begin
      if (req && we && addr[7] && addr[3:2] == 2'd0) ctrl_m <= wdata & 32'h1000F3;
      if (req && we && addr[7] && addr[3:2] == 2'd2) tim_m  <= wdata & 32'h3FFFF;
      if (age != 0) begin
        if (age == s_len && cur_rd) exp_data <= dq_in;
        if (age == t_len) begin age <= 0; comp_m <= 1'b1; end
        else age <= age + 1;
      end
      if (req && !addr[7] && age == 0) begin
        if (ctrl_m[0]) begin
          int m, w;
          m = int'(tim_m[17:16]) + 1;
          w = we ? int'(tim_m[7:4]) : int'(tim_m[3:0]);
          s_len  <= (w + 1) * m;
          sh_len <= (w + 1 + int'(tim_m[11:8])) * m;
          t_len  <= (w + 1 + int'(tim_m[11:8]) + int'(tim_m[15:12])) * m;
          age    <= 1;
          cur_rd <= !we;
          bits_m <= addr[6:2];
          byte_m <= wdata[7:0];
          comp_m <= 1'b0;
        end else if (!we) begin
          exp_data <= '0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic act;
      act = (age != 0);
      if (!we_n) we_low_cnt++;
      chk("R3 we_n", we_n, !(act && !cur_rd && age <= s_len));
      chk("R4 re_n", re_n, !(act && cur_rd && age <= s_len));
      chk("R3 dq_oe", dq_oe, act && !cur_rd && age <= sh_len);
      if (dq_oe) chk("R3 dq_o", dq_out, byte_m);
      chk("R1 cle", cle, act && bits_m[1]);
      chk("R1 ale", ale, act && bits_m[0]);
      chk("R2 cs", cs, (act && bits_m[2] && ctrl_m[20] && ctrl_m[0]) ^ ctrl_m[4]);
      chk("R2 spare", spare, (act && bits_m[3]) ^ ctrl_m[5]);
      chk("R2 wp", wp, (act && bits_m[4]) ^ ctrl_m[6]);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic poll_done();
    logic [31:0] s;
    s = '0;
    while (!s[3]) bus_read(8'h84, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; dq_in = 8'h11; rb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 we_n reset", we_n, 1'b1);
    chk("R10 re_n reset", re_n, 1'b1);
    chk("R10 cle reset", cle, 1'b0);
    chk("R10 ale reset", ale, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    bus_read(8'h80, d); chk("R10 ctrl reset", d, 32'h0);
    bus_read(8'h84, d); chk("R10 status reset", d, 32'h9);
    bus_read(8'h88, d); chk("R6 timing reset", d, 32'h31122);

    bus_write(8'h80, 32'hFFFF_FFFF);
    bus_read(8'h80, d); chk("R9 ctrl mask", d, 32'h1000F3);
    bus_write(8'h80, 32'h1000F1);
    bus_read(8'h80, d); chk("R9 ctrl readback", d, 32'h1000F1);

    // reset command in command-latch mode, default timing
    bus_write(8'h18, 32'hFF);
    bus_read(8'h84, d); chk("R5 complete cleared", d, 32'h1);
    poll_done();
    bus_read(8'h84, d); chk("R5 complete set", d, 32'h9);

    // shortest write: one-cycle strobe, address latch
    bus_write(8'h88, 32'h00001);
    bus_write(8'h14, 32'h5A);
    poll_done();

    // read with stretched timing
    bus_write(8'h88, 32'h11213);
    bus_read(8'h10, d); chk("R11 flash read returns zero", d, 32'h0);
    poll_done();
    bus_read(8'h8C, d); chk("R4 captured byte", d, {24'h0, exp_data});

    // back-to-back request while busy
    bus_write(8'h88, 32'h31122);
    we_low_cnt = 0;
    bus_write(8'h10, 32'h33);
    bus_write(8'h08, 32'h44);
    poll_done();
    chk("R7 single strobe length", we_low_cnt, 12);

    // active-high polarities, spare and write protect
    bus_write(8'h80, 32'h100001);
    bus_write(8'h70, 32'h00);
    chk("R2 cs active high", cs, 1'b1);
    chk("R2 spare active high", spare, 1'b1);
    chk("R2 wp active high", wp, 1'b1);
    poll_done();

    // chip enable off: cs stays inactive
    bus_write(8'h80, 32'h000001);
    bus_write(8'h10, 32'h00);
    chk("R2 cs gated by chip enable", cs, 1'b0);
    poll_done();

    // mode disabled
    bus_write(8'h80, 32'h0000F0);
    bus_write(8'h1C, 32'hA5);
    chk("R8 no write strobe", we_n, 1'b1);
    chk("R8 cs inactive", cs, 1'b1);
    bus_read(8'h84, d); chk("R8 complete stays set", d, 32'h9);
    bus_read(8'h10, d); chk("R11 bypass read zero", d, 32'h0);
    bus_read(8'h8C, d); chk("R8 data cleared", d, 32'h0);

    // ready/busy reflection
    rb = 1'b0;
    bus_read(8'h84, d); chk("R5 rb low", d, 32'h8);
    rb = 1'b1;
    bus_read(8'h84, d); chk("R5 rb high", d, 32'h9);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule